// File: doc/BRIEF.md
# Compensated Truncated Fractional Multiplier

This block multiplies two unsigned fractional operands of `N` bits and returns an `N`-bit product. The most significant operand bit is worth one half. The block does not build the whole partial-product matrix. It forms only the `N+K` most significant product columns. The bits of the first discarded column are folded into the lowest kept column. This estimates the carry that the dropped columns would have produced. A small constant is also added to stand in for the rounding lost when the `N+K`-bit sum is cut back to `N` bits. The result is within one unit in the last place of the truncated exact product, at a fraction of the adder count of a full array.

A runtime invert input complements every product bit. This gives `1 - A*B` (less one ulp) for the correction step of a reciprocal-root iteration. When the parameter `OUT_REG` is 1 (the default), the product is registered and appears one clock after the operands are sampled. When it is 0, the path is purely combinational. The defaults `N=16` and `K=3` are one case of the configuration and need not be used. Another case is `N=25`, `K=3`.

Top module: `trunc_frac_mul`

## Requirements
- R1: With `OUT_REG=1`, a rising clock edge while `rst_n` is low sets `prod_o` to zero, whatever the operands are.
- R2: With `OUT_REG=1`, `prod_o` shows the result for the operands and `inv_i` present at one rising edge from just after that edge. Between edges it holds that value.
- R3: Operand bit `N-1` (the MSB) has weight 2^-1 and bit 0 has weight 2^-N. Product bit `N-1-m` has weight 2^-(m+1), so the output integer is the product in units of 2^-N.
- R4: If either operand is zero and `inv_i` is 0, the product is exactly zero. The compensation constant alone never reaches the kept bits.
- R5: If `a_i` is exactly one half (only the MSB set) and `inv_i` is 0, the product equals `b_i` shifted right by one bit, with no error.
- R6: For every operand pair with `inv_i` = 0, and with the default `N=16`, `K=3`, `|prod_o - floor(a*b / 2^N)|` is at most 1.
- R7: With `inv_i` = 1, `prod_o` is the bitwise complement of the product that the same operands give with `inv_i` = 0.
- R8: The compensated sum never passes 1.0. Even all-ones times all-ones gives a large product near full scale and never wraps to a small value.
- R9: Swapping `a_i` and `b_i` does not change the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | N | Multiplicand, unsigned fraction, MSB worth 1/2 |
| b_i | input | N | Multiplier, unsigned fraction, MSB worth 1/2 |
| inv_i | input | 1 | When 1, the product bits are complemented |
| prod_o | output | N | Truncated compensated product, or its complement |

## Verification
The bench uses zero operands and an exact one-half operand. In both cases no discarded column carries weight, so any stray compensation or misplaced column shows up as a one-ulp offset. Operands with all ones, single bits and alternating bits load the deepest columns and the first dropped column. These expose a missing fold or a wrong constant as an error above one ulp, or as a wrap. Several thousand random pairs are each applied in both orders and with the invert input both ways. This separates a bound violation, an asymmetric column build and a faulty complement path.

// File: rtl/tmul_pkg.sv
// Shared helpers for the truncated fractional multiplier.
// Assumes column j (weight 2^-j) of an N x N fractional product spans 2..2N.
package tmul_pkg;

    // Number of partial-product bits that fall in column j.
    function automatic int col_height(input int j, input int n);
        int lo;
        int hi;
        lo = (j - n > 1) ? j - n : 1;
        hi = (j - 1 < n) ? j - 1 : n;
        return (hi >= lo) ? hi - lo + 1 : 0;
    endfunction

    // Value that stands in for the rounding lost below the kept columns:
    // ones in columns N+2..N+K, in units of 2^-(N+K).
    function automatic int trunc_corr(input int k);
        return (k >= 1) ? (1 << (k - 1)) - 1 : 0;
    endfunction

endpackage

// File: rtl/tmul_column.sv
// Counts the partial-product bits a_i*b_(J-i) of one product column J.
// Assumes operand bit of weight 2^-i sits at vector index N-i.
module tmul_column #(
    parameter int N  = 16,
    parameter int J  = 2,
    parameter int CW = 5
) (
    input  logic [N-1:0]  a,
    input  logic [N-1:0]  b,
    output logic [CW-1:0] cnt
);
    localparam int LO = (J - N > 1) ? J - N : 1;
    localparam int HI = (J - 1 < N) ? J - 1 : N;

    // Population count of the AND terms lying on this column.
    always_comb begin
        cnt = '0;
        for (int i = LO; i <= HI; i++) begin
            cnt = cnt + CW'(a[N-i] & b[N-(J-i)]);
        end
    end
endmodule

// File: rtl/tmul_reduce.sv
// Weighs the kept column counts, folds the first dropped column into the
// lowest kept one, adds the truncation constant and returns the raw sum.
// Assumes cnt[c] belongs to column c+2; the last entry is column N+K+1.
module tmul_reduce #(
    parameter int N    = 16,
    parameter int K    = 3,
    parameter int CW   = 5,
    parameter int NCOL = N + K,
    parameter int SW   = N + K + 2
) (
    input  logic [NCOL-1:0][CW-1:0] cnt,
    output logic [SW-1:0]           sum
);
    localparam int CORR = tmul_pkg::trunc_corr(K);

    // Shift of column c within a sum scaled by 2^(N+K); the extra column
    // shares the weight of column N+K.
    function automatic int col_shift(input int c);
        int j;
        j = c + 2;
        return (j <= N + K) ? N + K - j : 0;
    endfunction

    // Weighted accumulation of all kept and folded columns.
    always_comb begin
        sum = SW'(CORR);
        for (int c = 0; c < NCOL; c++) begin
            sum = sum + (SW'(cnt[c]) << col_shift(c));
        end
    end
endmodule

// File: rtl/trunc_frac_mul.sv
// Truncated unsigned fractional multiplier with column compensation and
// optional result inversion. Builds columns 2..N+K+1 only; output is the
// top N bits of the compensated sum, optionally registered.
// Assumes K >= 1 and K < N.
module trunc_frac_mul #(
    parameter int N       = 16,
    parameter int K       = 3,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         inv_i,
    output logic [N-1:0] prod_o
);
    localparam int CW   = $clog2(N + 1);
    localparam int NCOL = N + K;
    localparam int SW   = N + K + 2;
    localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

    logic [NCOL-1:0][CW-1:0] col_cnt;
    logic [SW-1:0]           raw_sum;
    logic [N-1:0]            kept;
    logic [N-1:0]            res;

    // One counter per generated column, columns 2..N+K+1.
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        tmul_column #(.N(N), .J(c + 2), .CW(CW)) u_col (
            .a   (a_i),
            .b   (b_i),
            .cnt (col_cnt[c])
        );
    end

    tmul_reduce #(.N(N), .K(K), .CW(CW), .NCOL(NCOL), .SW(SW)) u_red (
        .cnt (col_cnt),
        .sum (raw_sum)
    );

    // Drop the K guard columns; clamp if the sum ever reached 1.0.
    always_comb begin
        if (raw_sum[SW-1:N+K] != '0) kept = '1;
        else                         kept = raw_sum[N+K-1:K];
        res = inv_i ? ~kept : kept;
    end

    if (OUT_REG) begin : g_reg
        // Output register with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) prod_o <= '0;
            else        prod_o <= res;
        end

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> prod_o == '0);
        // R4
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((a_i == '0 || b_i == '0) && !inv_i) |=> prod_o == '0);
        // R5
        half_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_i == HALF && !inv_i) |=> prod_o == ($past(b_i) >> 1));
        // R7
        inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (b_i == '0 && inv_i) |=> prod_o == '1);
        // R8
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raw_sum[SW-1:N+K] == '0);
    end else begin : g_comb
        // Unregistered output.
        always_comb prod_o = res;
    end
endmodule

// File: tb/trunc_frac_mul_tb.sv
`timescale 1ns/1ps
module trunc_frac_mul_tb;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a_i = '0;
    logic [N-1:0] b_i = '0;
    logic         inv_i = 1'b0;
    logic [N-1:0] prod_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    trunc_frac_mul #(.N(N), .K(3), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
        .inv_i(inv_i), .prod_o(prod_o)
    );

    always #5 clk = ~clk;

    // Exact-match check.
    task automatic chk_eq(input string req, input logic [N-1:0] act,
                          input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-ulp bound against the truncated exact product.
    task automatic chk_bound(input string req, input logic [N-1:0] a,
                             input logic [N-1:0] b, input logic [N-1:0] act);
        longint t;
        longint d;
        t = (longint'(a) * longint'(b)) >>> N;
        d = longint'(act) - t;
        checks++;
        if (d > 1 || d < -1) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h (+/-1)",
                     req, a, b, act, t[N-1:0]);
        end
    endtask

    // Drive on the falling edge, return the registered result after the next rise.
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic inv, output logic [N-1:0] r);
        @(negedge clk);
        a_i = a; b_i = b; inv_i = inv;
        @(posedge clk);
        #1 r = prod_o;
    endtask

    // Full check of one pair: bound, swap symmetry, inversion.
    task automatic pair(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N-1:0] p, q, v;
        apply(a, b, 1'b0, p);
        chk_bound("R6", a, b, p);
        apply(b, a, 1'b0, q);
        chk_eq("R9", q, p);
        apply(a, b, 1'b1, v);
        chk_eq("R7", v, ~p);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] r, r0;
        // R1: reset clears the register even with live operands.
        a_i = 16'hFFFF; b_i = 16'hFFFF; inv_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk_eq("R1", prod_o, '0);
        @(negedge clk) rst_n = 1'b1;

        // R2: value held until the edge, new value just after it.
        apply(16'h8000, 16'h4000, 1'b0, r0);       // 0.5*0.25 = 0.125
        chk_eq("R3", r0, 16'h2000);
        @(negedge clk);
        a_i = 16'h4000; b_i = 16'h4000;             // 0.0625
        #1 chk_eq("R2", prod_o, 16'h2000);
        @(posedge clk);
        #1 chk_eq("R2", prod_o, 16'h1000);

        // R4: zero operands.
        apply(16'h0000, 16'hFFFF, 1'b0, r); chk_eq("R4", r, '0);
        apply(16'hABCD, 16'h0000, 1'b0, r); chk_eq("R4", r, '0);
        apply(16'h0000, 16'h0000, 1'b1, r); chk_eq("R7", r, 16'hFFFF);

        // R5: multiplying by one half is exact.
        apply(16'h8000, 16'hFFFF, 1'b0, r); chk_eq("R5", r, 16'h7FFF);
        apply(16'h8000, 16'h1235, 1'b0, r); chk_eq("R5", r, 16'h091A);
        apply(16'h0001, 16'h8000, 1'b0, r); chk_eq("R5", r, 16'h0000);

        // R8: full-scale operands stay near full scale.
        apply(16'hFFFF, 16'hFFFF, 1'b0, r);
        chk_bound("R8", 16'hFFFF, 16'hFFFF, r);
        checks++;
        if (r < 16'hFFF0) begin
            errors++;
            $display("FAIL R8 actual=%h expected>=fff0", r);
        end

        // Structured patterns load the deep and dropped columns.
        pair(16'hFFFF, 16'hFFFE);
        pair(16'hAAAA, 16'h5555);
        pair(16'hAAAA, 16'hAAAA);
        pair(16'h5555, 16'h5555);
        pair(16'h0001, 16'hFFFF);
        pair(16'h00FF, 16'hFF00);
        for (int s = 0; s < N; s++) pair(16'h1 << s, 16'hFFFF >> s);

        // Random sweep.
        for (int t = 0; t < 3000; t++) pair(N'($urandom), N'($urandom));

        // R1 again: mid-run reset.
        @(negedge clk) rst_n = 1'b0; a_i = 16'h9999; b_i = 16'h7777;
        @(posedge clk);
        #1 chk_eq("R1", prod_o, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule